// File: doc/BRIEF.md
# Multi-Context Instruction Fetch Arbiter

This block decides, every clock cycle, which hardware thread slot may start an instruction fetch. Each slot reports whether it is running, how many entries its instruction buffer holds, and whether a branch sits in that buffer. A slot that passes the fetch test goes into an oldest-first ready queue. The block grants at most one queued slot per cycle.

On a grant, the block pulses a one-cycle fetch-start strobe that carries the slot index. It also marks that slot as having a fetch in flight. When the surrounding fetch path has processed the returned instructions, it reports completion for the slot, and the in-flight mark is removed. Address generation, memory access and decode are handled by neighbouring logic.

Two rules keep fetch conservative. A slot whose buffer already holds a branch is not fetched past it, and a slot whose buffer is filling up waits. A per-slot "queued" mark makes sure a slot occupies at most one place in the ready queue.

Top module: `fetch_arbiter`

## Requirements
- R1: In a cycle with reset low, slot i is enqueued only when all of the following hold: `slot_running[i]` is 1; `slot_buf_count[i*OCC_W +: OCC_W]` is at most OCC_LIMIT (default 4, so a count of 4 qualifies and 5 does not); `slot_branch[i]` is 0; slot i has no fetch in flight; and slot i is not already queued. A slot with a fetch in flight is never enqueued.
- R2: Once enqueued, a slot stays queued and is granted in its turn even if its status inputs stop qualifying. It is never enqueued a second time before that grant.
- R3: Grants follow enqueue order, oldest first. Slots enqueued in the same cycle are ordered by ascending slot index. The queue holds NUM_SLOTS entries and never overflows.
- R4: When the ready queue is empty at a clock edge, `fetch_start` is 0 after that edge. At most one grant is made per cycle.
- R5: A slot enqueued at edge E is granted at edge E+1 if the queue was otherwise empty. After the grant edge, `fetch_start` is 1 for exactly one cycle and `fetch_slot` holds the granted index. The slot's bit of `fetch_pending` is 1 from that edge, and its queued mark is cleared.
- R6: `done_valid` with `done_slot` = i clears bit i of `fetch_pending` at the next edge. A grant to the same slot in that cycle takes precedence. After clearing, the slot can qualify again under R1.
- R7: Synchronous active-high `rst` clears all in-flight and queued marks, empties the queue, and holds `fetch_start` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_running | input | NUM_SLOTS | Slot i is in the running state |
| slot_buf_count | input | NUM_SLOTS*OCC_W | Instruction buffer occupancy, OCC_W bits per slot, slot i at bits i*OCC_W |
| slot_branch | input | NUM_SLOTS | Slot i's buffer holds a branch |
| done_valid | input | 1 | Fetch return for `done_slot` has been processed |
| done_slot | input | SLOT_W | Slot whose fetch completed |
| fetch_start | output | 1 | One-cycle fetch-start strobe |
| fetch_slot | output | SLOT_W | Slot index of the current strobe |
| fetch_pending | output | NUM_SLOTS | Per-slot fetch-in-flight flags |

## Verification
The bench drives several slots that qualify in the same cycle. A queue that pushed only one slot per cycle, or pushed them in the wrong order, would drop or reorder grants. It also covers a slot whose status goes away while it waits in the queue; a design that re-checked status at grant time would silently skip that slot. It tests buffer occupancy exactly at the limit and one above it, and a branch in the buffer, because an off-by-one threshold or a missing branch test would issue a speculative fetch. Completions, including ones that arrive for idle slots, are checked against the in-flight flags: a missed clear would starve a slot, and a spurious clear would let a slot fetch twice.

// File: rtl/fetch_arb_pkg.sv
package fetch_arb_pkg;

  // Fetch qualification test for one slot. Occupancy is compared as an
  // unsigned integer against the throttle limit.
  function automatic logic slot_may_fetch(
    input logic        running,
    input logic        has_branch,
    input logic        in_flight,
    input logic        queued,
    input int unsigned occupancy,
    input int unsigned limit
  );
    return running && !has_branch && !in_flight && !queued && (occupancy <= limit);
  endfunction

  // Width needed to carry a slot index, never less than one bit.
  function automatic int unsigned index_width(input int unsigned slots);
    return (slots > 1) ? $clog2(slots) : 1;
  endfunction

endpackage

// File: rtl/fetch_slot_gate.sv
module fetch_slot_gate
  import fetch_arb_pkg::*;
#(
  parameter int unsigned OCC_W     = 4,
  parameter int unsigned OCC_LIMIT = 4
) (
  input  logic             running,
  input  logic             has_branch,
  input  logic [OCC_W-1:0] occupancy,
  input  logic             in_flight,
  input  logic             queued,
  output logic             want_push
);

  always_comb begin
    want_push = slot_may_fetch(running, has_branch, in_flight, queued,
                               32'(occupancy), OCC_LIMIT);
  end

endmodule

// File: rtl/fetch_ready_queue.sv
module fetch_ready_queue #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned SLOT_W    = 3,
  parameter int unsigned CNT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SLOTS-1:0] push_vec,
  input  logic                 pop,
  output logic [SLOT_W-1:0]    head,
  output logic                 not_empty,
  output logic [CNT_W-1:0]     level
);

  localparam logic [CNT_W-1:0] DEPTH = CNT_W'(NUM_SLOTS);

  logic [SLOT_W-1:0] mem_q   [NUM_SLOTS];
  logic [SLOT_W-1:0] mem_nxt [NUM_SLOTS];
  logic [CNT_W-1:0]  lvl_q;
  logic [CNT_W-1:0]  lvl_nxt;

  // The head leaves first (shift down); then this cycle's pushes are
  // appended in ascending slot order behind the survivors.
  always_comb begin
    for (int k = 0; k < NUM_SLOTS; k++) mem_nxt[k] = mem_q[k];
    lvl_nxt = lvl_q;
    if (pop && (lvl_q != '0)) begin
      for (int k = 0; k < NUM_SLOTS - 1; k++) mem_nxt[k] = mem_q[k+1];
      mem_nxt[NUM_SLOTS-1] = '0;
      lvl_nxt = lvl_q - 1'b1;
    end
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (push_vec[s]) begin
        if (lvl_nxt < DEPTH) mem_nxt[lvl_nxt[SLOT_W-1:0]] = SLOT_W'(s);
        lvl_nxt = lvl_nxt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      for (int k = 0; k < NUM_SLOTS; k++) mem_q[k] <= '0;
    end else begin
      lvl_q <= lvl_nxt;
      for (int k = 0; k < NUM_SLOTS; k++) mem_q[k] <= mem_nxt[k];
    end
  end

  assign head      = mem_q[0];
  assign not_empty = (lvl_q != '0);
  assign level     = lvl_q;

endmodule

// File: rtl/fetch_arbiter.sv
module fetch_arbiter
  import fetch_arb_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned OCC_W     = 4,
  parameter int unsigned OCC_LIMIT = 4,
  localparam int unsigned SLOT_W   = index_width(NUM_SLOTS),
  localparam int unsigned CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SLOTS-1:0]       slot_running,
  input  logic [NUM_SLOTS*OCC_W-1:0] slot_buf_count,
  input  logic [NUM_SLOTS-1:0]       slot_branch,
  input  logic                       done_valid,
  input  logic [SLOT_W-1:0]          done_slot,
  output logic                       fetch_start,
  output logic [SLOT_W-1:0]          fetch_slot,
  output logic [NUM_SLOTS-1:0]       fetch_pending
);

  // Named internal events (also observed by the bound checker)
  logic [NUM_SLOTS-1:0] push_vec;
  logic [NUM_SLOTS-1:0] grant_vec;
  logic [NUM_SLOTS-1:0] done_vec;
  logic [NUM_SLOTS-1:0] queued_q;
  logic [NUM_SLOTS-1:0] pending_q;
  logic                 grant_valid;
  logic [SLOT_W-1:0]    grant_slot;
  logic [CNT_W-1:0]     q_level;
  logic                 start_q;
  logic [SLOT_W-1:0]    slot_q;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    fetch_slot_gate #(
      .OCC_W    (OCC_W),
      .OCC_LIMIT(OCC_LIMIT)
    ) u_gate (
      .running   (slot_running[i]),
      .has_branch(slot_branch[i]),
      .occupancy (slot_buf_count[i*OCC_W +: OCC_W]),
      .in_flight (pending_q[i]),
      .queued    (queued_q[i]),
      .want_push (push_vec[i])
    );
    assign grant_vec[i] = grant_valid && (grant_slot == SLOT_W'(i));
    assign done_vec[i]  = done_valid  && (done_slot  == SLOT_W'(i));
  end

  fetch_ready_queue #(
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_W   (SLOT_W),
    .CNT_W    (CNT_W)
  ) u_queue (
    .clk      (clk),
    .rst      (rst),
    .push_vec (push_vec),
    .pop      (grant_valid),
    .head     (grant_slot),
    .not_empty(grant_valid),
    .level    (q_level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      queued_q  <= '0;
      pending_q <= '0;
      start_q   <= 1'b0;
      slot_q    <= '0;
    end else begin
      queued_q  <= (queued_q | push_vec) & ~grant_vec;
      pending_q <= (pending_q & ~done_vec) | grant_vec;
      start_q   <= grant_valid;
      if (grant_valid) slot_q <= grant_slot;
    end
  end

  assign fetch_start   = start_q;
  assign fetch_slot    = slot_q;
  assign fetch_pending = pending_q;

endmodule

// File: rtl/fetch_arbiter_chk.sv
module fetch_arbiter_chk #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned SLOT_W    = 3,
  parameter int unsigned CNT_W     = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_SLOTS-1:0] slot_running,
  input logic [NUM_SLOTS-1:0] slot_branch,
  input logic                 done_valid,
  input logic [SLOT_W-1:0]    done_slot,
  input logic                 fetch_start,
  input logic [SLOT_W-1:0]    fetch_slot,
  input logic [NUM_SLOTS-1:0] fetch_pending,
  input logic [NUM_SLOTS-1:0] push_vec,
  input logic                 grant_valid,
  input logic [SLOT_W-1:0]    grant_slot,
  input logic [CNT_W-1:0]     q_level
);

  logic              clr_hit_q;
  logic [SLOT_W-1:0] clr_slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_hit_q  <= 1'b0;
      clr_slot_q <= '0;
    end else begin
      clr_hit_q  <= done_valid && !(grant_valid && (grant_slot == done_slot));
      clr_slot_q <= done_slot;
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot_chk
    assert_push_qualified_R1: assert property (@(posedge clk) disable iff (rst)
      push_vec[i] |-> (slot_running[i] && !slot_branch[i] && !fetch_pending[i]));
    assert_single_enqueue_R2: assert property (@(posedge clk) disable iff (rst)
      push_vec[i] |=> !push_vec[i]);
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    q_level <= CNT_W'(NUM_SLOTS));

  assert_idle_when_empty_R4: assert property (@(posedge clk) disable iff (rst)
    (q_level == '0) |=> !fetch_start);

  assert_strobe_carries_slot_R5: assert property (@(posedge clk) disable iff (rst)
    grant_valid |=> (fetch_start && (fetch_slot == $past(grant_slot))));

  assert_grant_marks_pending_R5: assert property (@(posedge clk) disable iff (rst)
    fetch_start |-> fetch_pending[fetch_slot]);

  assert_done_clears_R6: assert property (@(posedge clk) disable iff (rst)
    clr_hit_q |-> !fetch_pending[clr_slot_q]);

  assert_reset_clears_R7: assert property (@(posedge clk)
    rst |=> (!fetch_start && (fetch_pending == '0)));

endmodule

bind fetch_arbiter fetch_arbiter_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .SLOT_W   (SLOT_W),
  .CNT_W    (CNT_W)
) u_fetch_arbiter_chk (
  .clk          (clk),
  .rst          (rst),
  .slot_running (slot_running),
  .slot_branch  (slot_branch),
  .done_valid   (done_valid),
  .done_slot    (done_slot),
  .fetch_start  (fetch_start),
  .fetch_slot   (fetch_slot),
  .fetch_pending(fetch_pending),
  .push_vec     (push_vec),
  .grant_valid  (grant_valid),
  .grant_slot   (grant_slot),
  .q_level      (q_level)
);

// File: tb/test_fetch_arbiter.sv
module test_fetch_arbiter;

  localparam int N     = 8;
  localparam int OCC_W = 4;
  localparam int LIMIT = 4;
  localparam int SW    = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N-1:0]     running = '0;
  logic [N*OCC_W-1:0] counts = '0;
  logic [N-1:0]     branch = '0;
  logic             done_valid = 1'b0;
  logic [SW-1:0]    done_slot = '0;
  logic             fetch_start;
  logic [SW-1:0]    fetch_slot;
  logic [N-1:0]     fetch_pending;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  fetch_arbiter #(.NUM_SLOTS(N), .OCC_W(OCC_W), .OCC_LIMIT(LIMIT)) i_fetch_arbiter (
    .clk(clk), .rst(rst), .slot_running(running), .slot_buf_count(counts),
    .slot_branch(branch), .done_valid(done_valid), .done_slot(done_slot),
    .fetch_start(fetch_start), .fetch_slot(fetch_slot), .fetch_pending(fetch_pending)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: a queue of slot numbers and two flag arrays
  int     ref_q[$];
  bit [N-1:0] m_pend = '0, m_queued = '0;
  bit     m_start = 1'b0;
  int     m_slot = 0;
  int     strobes[$];

  always @(posedge clk) begin : model
    bit gok; int g; bit [N-1:0] np, nq;
    if (rst) begin
      ref_q.delete(); m_pend = '0; m_queued = '0; m_start = 1'b0;
    end else begin
      gok = (ref_q.size() != 0);
      g = gok ? ref_q[0] : 0;
      np = m_pend; nq = m_queued;
      if (gok) void'(ref_q.pop_front());
      for (int s = 0; s < N; s++)
        if (running[s] && !branch[s] && int'(counts[s*OCC_W +: OCC_W]) <= LIMIT &&
            !m_pend[s] && !m_queued[s]) begin
          ref_q.push_back(s); nq[s] = 1'b1;
        end
      if (gok) begin nq[g] = 1'b0; np[g] = 1'b1; end
      if (done_valid && !(gok && g == int'(done_slot))) np[done_slot] = 1'b0;
      m_pend = np; m_queued = nq; m_start = gok;
      if (gok) m_slot = g;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(fetch_start == m_start, "R5 strobe", int'(fetch_start), int'(m_start));
      if (m_start) check(int'(fetch_slot) == m_slot, "R3 grant order", int'(fetch_slot), m_slot);
      check(fetch_pending == m_pend, "R6 pending flags", int'(fetch_pending), int'(m_pend));
      if (fetch_start) strobes.push_back(int'(fetch_slot));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", cycles, 150000);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_cnt(input int s, input int v);
    counts[s*OCC_W +: OCC_W] = OCC_W'(v);
  endtask

  task automatic expect_log(input string req, input int a, input int b, input int c);
    check(strobes.size() == 3, req, strobes.size(), 3);
    if (strobes.size() == 3) begin
      check(strobes[0] == a, req, strobes[0], a);
      check(strobes[1] == b, req, strobes[1], b);
      check(strobes[2] == c, req, strobes[2], c);
    end
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    check(fetch_start == 1'b0, "R7 reset strobe", int'(fetch_start), 0);
    check(fetch_pending == '0, "R7 reset pending", int'(fetch_pending), 0);

    // R1: occupancy one above the limit, and a branch in the buffer
    set_cnt(2, 5); running[2] = 1'b1;
    set_cnt(3, 0); running[3] = 1'b1; branch[3] = 1'b1;
    tick(5);
    check(strobes.size() == 0, "R1 over limit or branch", strobes.size(), 0);
    check(fetch_start == 1'b0, "R4 empty queue idle", int'(fetch_start), 0);
    set_cnt(2, 4);
    tick(2);
    check(fetch_start && fetch_slot == 2, "R1 at limit", int'(fetch_slot), 2);
    running = '0; branch = '0;
    done_valid = 1'b1; done_slot = 3'd2;
    tick(1);
    done_valid = 1'b0;
    tick(2);
    strobes.delete();

    // R3: same-cycle pushes go out in ascending slot order
    set_cnt(6, 0); set_cnt(1, 3); set_cnt(5, 1);
    running[6] = 1'b1; running[1] = 1'b1; running[5] = 1'b1;
    tick(6);
    expect_log("R3 same-cycle order", 1, 5, 6);
    strobes.delete();

    // R2: status drops after enqueue, grants still happen once each
    set_cnt(0, 0); set_cnt(4, 0); set_cnt(7, 2);
    running[0] = 1'b1; running[4] = 1'b1; running[7] = 1'b1;
    tick(1);
    running[0] = 1'b0; running[4] = 1'b0; running[7] = 1'b0;
    tick(6);
    expect_log("R2 queued slot kept", 0, 4, 7);
    strobes.delete();

    // R6: completion clears pending, slot 1 (still running) fetches again
    done_valid = 1'b1; done_slot = 3'd1;
    tick(1);
    done_valid = 1'b0;
    check(fetch_pending[1] == 1'b0, "R6 clear", int'(fetch_pending[1]), 0);
    tick(2);
    check(fetch_start && fetch_slot == 1, "R6 refetch", int'(fetch_slot), 1);
    tick(3);
    check(strobes.size() == 1, "R6 single refetch", strobes.size(), 1);

    // R7: reset in the middle of activity
    rst = 1'b1;
    tick(2);
    check(fetch_pending == '0 && fetch_start == 1'b0, "R7 mid-run reset",
          int'(fetch_pending), 0);
    rst = 1'b0;
    running = '0;
    tick(2);

    // Mixed traffic against the reference model
    for (int c = 0; c < 3000; c++) begin
      for (int s = 0; s < N; s++) begin
        running[s] = ($urandom_range(0, 3) != 0);
        branch[s]  = ($urandom_range(0, 3) == 0);
        set_cnt(s, $urandom_range(0, 6));
      end
      done_valid = ($urandom_range(0, 2) == 0);
      done_slot  = SW'($urandom_range(0, N - 1));
      tick(1);
    end
    done_valid = 1'b0;
    running = '0;
    tick(12);
    check(fetch_start == 1'b0, "R4 drained", int'(fetch_start), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule